// File: doc/BRIEF.md
# Sequential Group Controller

This block sequences a fixed list of sub-tasks, called groups, strictly one after another. Each group is started by its own request line and answers on its own completion line. The controller keeps one small counter whose value is the index of the group that is running. When that group's completion line rises, the counter moves to the next index. After the last group, the counter reaches one extra terminal code. That code raises the overall completion output for exactly one cycle and then returns the counter to group 0.

The sequence moves forward only while the overall start input is held high. Dropping it freezes the sequence and silences every group request. Each group's request is also masked by that group's own completion line, so a group never sees a request and a completion together. The completion line may carry any condition the surrounding logic forms, for example a done bit qualified by a flag. External logic reads the running index to decode which group owns shared resources.

Top module: `seq_group_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the running index to 0. No group request is asserted while reset is high.
- R2: The running index output equals the number of the group being run. Groups are visited in ascending order 0 to NUM_GROUPS-1, and the terminal code is NUM_GROUPS.
- R3: Request bit i is high only when start is high, reset is low, the index equals i and completion bit i is low. At most one request bit is high in any cycle.
- R4: When start is high and the completion bit of the running group is high, the index becomes index+1 on the next clock edge.
- R5: While the running group's completion bit stays low, the index holds and that group's request stays high, for any number of cycles.
- R6: When start is low outside the terminal code, all request bits are low and the index holds, even if completion bits are high.
- R7: The overall completion output is high exactly when the index equals NUM_GROUPS. All request bits are low in that cycle.
- R8: From the terminal code the index returns to 0 on the next clock edge, whether start is high or low.
- R9: Completion bits of groups other than the running one have no effect on the index or on the request bits.
- R10: After the wrap to 0, a new run starts at once if start is still high, so runs can follow back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Overall go; the sequence advances only while high |
| grp_done | input | NUM_GROUPS | Completion line of each group |
| grp_go | output | NUM_GROUPS | Request line of each group |
| active_idx | output | STATE_W | Index of the running group, NUM_GROUPS when finished |
| all_done | output | 1 | High for the one cycle spent in the terminal code |

## Verification
The bound checker covers the properties that hold on every cycle. It checks that at most one request is high, that requests are gated by start and by the terminal code, that the index steps by exactly one on a qualified completion, that it holds when start is low, and that the terminal code always wraps to 0. The ordering of a whole run can only be shown by the bench's scenarios. The same goes for multi-cycle completion latency, a pause in the middle of a run followed by its resumption, completions from idle groups being ignored, and runs following each other with no gap. The bench checks these against a cycle model, along with a long pseudo-random sweep over the start, reset and completion inputs.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    // Kind of move the index register makes on the next edge
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_WRAP = 2'd2
    } seq_step_e;

    // Bits needed to hold group indices plus the terminal code
    function automatic int unsigned idx_bits(input int unsigned n_groups);
        return (n_groups < 1) ? 1 : $clog2(n_groups + 1);
    endfunction

endpackage

// File: rtl/seqctl_done_pick.sv
module seqctl_done_pick #(
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned STATE_W    = 2
) (
    input  logic [STATE_W-1:0]    idx_q,
    input  logic [NUM_GROUPS-1:0] grp_done,
    output logic                  cur_done,
    output logic                  in_run
);
    localparam logic [STATE_W-1:0] TERM_CODE = STATE_W'(NUM_GROUPS);

    // Only the running group's completion line is looked at
    always_comb begin
        cur_done = 1'b0;
        for (int i = 0; i < int'(NUM_GROUPS); i++) begin
            if (idx_q == STATE_W'(i)) begin
                cur_done = grp_done[i];
            end
        end
    end

    assign in_run = (idx_q < TERM_CODE);

endmodule

// File: rtl/seqctl_go_decode.sv
module seqctl_go_decode #(
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned STATE_W    = 2
) (
    input  logic                  rst,
    input  logic                  start,
    input  logic [STATE_W-1:0]    idx_q,
    input  logic [NUM_GROUPS-1:0] grp_done,
    output logic [NUM_GROUPS-1:0] grp_go
);
    logic enable;
    assign enable = start & ~rst;

    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_go
        assign grp_go[g] = enable & (idx_q == STATE_W'(g)) & ~grp_done[g];
    end

endmodule

// File: rtl/seqctl_state_reg.sv
module seqctl_state_reg
    import seqctl_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned STATE_W    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cur_done,
    input  logic               in_run,
    output logic [STATE_W-1:0] idx_q
);
    typedef struct packed {
        logic [STATE_W-1:0] idx;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    seq_step_e step_d;

    always_comb begin
        regs_d = regs_q;
        if (!in_run) begin
            step_d = STEP_WRAP;
        end else if (start && cur_done) begin
            step_d = STEP_ADV;
        end else begin
            step_d = STEP_HOLD;
        end
        unique case (step_d)
            STEP_ADV:  regs_d.idx = regs_q.idx + STATE_W'(1);
            STEP_WRAP: regs_d.idx = '0;
            default:   regs_d.idx = regs_q.idx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign idx_q = regs_q.idx;

endmodule

// File: rtl/seq_group_ctrl.sv
module seq_group_ctrl #(
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned STATE_W    = seqctl_pkg::idx_bits(NUM_GROUPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NUM_GROUPS-1:0] grp_done,
    output logic [NUM_GROUPS-1:0] grp_go,
    output logic [STATE_W-1:0]    active_idx,
    output logic                  all_done
);
    localparam logic [STATE_W-1:0] TERM_CODE = STATE_W'(NUM_GROUPS);

    logic [STATE_W-1:0] idx_q;
    logic               cur_done;
    logic               in_run;

    seqctl_done_pick #(.NUM_GROUPS(NUM_GROUPS), .STATE_W(STATE_W)) pick_i (
        .idx_q    (idx_q),
        .grp_done (grp_done),
        .cur_done (cur_done),
        .in_run   (in_run)
    );

    seqctl_state_reg #(.NUM_GROUPS(NUM_GROUPS), .STATE_W(STATE_W)) state_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cur_done (cur_done),
        .in_run   (in_run),
        .idx_q    (idx_q)
    );

    seqctl_go_decode #(.NUM_GROUPS(NUM_GROUPS), .STATE_W(STATE_W)) go_i (
        .rst      (rst),
        .start    (start),
        .idx_q    (idx_q),
        .grp_done (grp_done),
        .grp_go   (grp_go)
    );

    assign active_idx = idx_q;
    assign all_done   = (idx_q == TERM_CODE);

endmodule

// File: rtl/seq_group_ctrl_chk.sv
module seq_group_ctrl_chk #(
    parameter int unsigned NUM_GROUPS = 3,
    parameter int unsigned STATE_W    = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [NUM_GROUPS-1:0] grp_done,
    input logic [NUM_GROUPS-1:0] grp_go,
    input logic [STATE_W-1:0]    active_idx,
    input logic                  all_done
);
    logic run_done;
    always_comb begin
        run_done = 1'b0;
        for (int i = 0; i < int'(NUM_GROUPS); i++) begin
            if (active_idx == STATE_W'(i)) run_done = grp_done[i];
        end
    end

    // R1
    always_comb begin
        if (rst) begin
            reset_quiet_chk: assert (grp_go == '0);
        end
    end

    // R3
    go_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_go));

    // R6
    go_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_go != '0) |-> start);

    // R7
    term_go_chk: assert property (@(posedge clk) disable iff (rst)
        all_done |-> (grp_go == '0));

    // R4
    adv_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !all_done && run_done) |=>
        (active_idx == STATE_W'($past(active_idx) + 1'b1)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !all_done) |=> $stable(active_idx));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        all_done |=> (active_idx == '0));

endmodule

bind seq_group_ctrl seq_group_ctrl_chk #(
    .NUM_GROUPS(NUM_GROUPS),
    .STATE_W   (STATE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .grp_done   (grp_done),
    .grp_go     (grp_go),
    .active_idx (active_idx),
    .all_done   (all_done)
);

// File: tb/seq_group_ctrl_tb_top.sv
module seq_group_ctrl_tb_top;
    localparam int N          = 3;
    localparam int SW         = $clog2(N + 1);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  grp_done = '0;
    logic [N-1:0]  grp_go;
    logic [SW-1:0] active_idx;
    logic          all_done;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_idx  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_group_ctrl #(.NUM_GROUPS(N)) dut_i (
        .clk(clk), .rst(rst), .start(start), .grp_done(grp_done),
        .grp_go(grp_go), .active_idx(active_idx), .all_done(all_done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] onehot(input int k);
        return (k < N) ? (N'(1) << k) : '0;
    endfunction

    // Apply inputs for one cycle, check outputs, then advance the model
    task automatic step(input logic r, input logic s, input logic [N-1:0] d, input string tag);
        logic [N-1:0] exp_go;
        rst = r; start = s; grp_done = d;
        #1;
        exp_go = '0;
        if (!r && s && exp_idx < N && !d[exp_idx]) exp_go = onehot(exp_idx);
        check({tag, " R2 index"}, int'(active_idx), exp_idx);
        check({tag, " R3 go"}, int'(grp_go), int'(exp_go));
        check({tag, " R7 done"}, int'(all_done), (exp_idx == N) ? 1 : 0);
        @(posedge clk);
        if (r)                         exp_idx = 0;
        else if (exp_idx == N)         exp_idx = 0;
        else if (s && d[exp_idx])      exp_idx = exp_idx + 1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R1: reset with start and completions active
        step(1'b1, 1'b1, '0, "R1");
        step(1'b1, 1'b1, '1, "R1");
        step(1'b0, 1'b0, '0, "R1");

        // R4: single-cycle groups through to terminal, then R8 wrap
        for (int k = 0; k <= N; k++) step(1'b0, 1'b1, onehot(exp_idx), "R4");
        check("R8 wrap", int'(active_idx), 0);

        // R5: each group takes four cycles to complete
        for (int g = 0; g < N; g++) begin
            for (int w = 0; w < 3; w++) step(1'b0, 1'b1, '0, "R5");
            step(1'b0, 1'b1, onehot(exp_idx), "R5");
        end
        // R8: terminal with start low still wraps
        step(1'b0, 1'b0, '0, "R8");
        check("R8 wrap no start", int'(active_idx), 0);

        // R6: pause in group 1 with its completion high
        step(1'b0, 1'b1, onehot(0), "R6");
        for (int w = 0; w < 3; w++) step(1'b0, 1'b0, '1, "R6");
        check("R6 held", int'(active_idx), 1);

        // R9: completions of idle groups ignored
        for (int w = 0; w < 3; w++) step(1'b0, 1'b1, ~onehot(1), "R9");
        check("R9 no move", int'(active_idx), 1);
        step(1'b0, 1'b1, onehot(1), "R9");
        step(1'b0, 1'b1, onehot(2), "R9");
        step(1'b0, 1'b1, '0, "R9");

        // R10: three runs back to back with start held
        for (int run = 0; run < 3; run++) begin
            for (int k = 0; k <= N; k++) step(1'b0, 1'b1, onehot(exp_idx), "R10");
            check("R10 restart", int'(active_idx), 0);
        end

        // R2: pseudo-random sweep over start, reset and completion bits
        lfsr = 16'hACE1;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[15:11] == 5'd0), lfsr[0] | lfsr[4], lfsr[N:1], "R2");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule